// File: doc/BRIEF.md
# Speculative Load Value Queue

This block passes load results from a leading thread to a redundant trailing thread. The leading thread, the only one that reads the data cache, pushes each load's address, its loaded value and a parity check bit in program order. The trailing thread never touches the cache. Instead it pops entries in the same order, takes the value from the queue, and presents its own computed load address. That address is compared with the stored one, so a fault in address generation is flagged when the trailing load executes. The stored check bit is also verified on every pop.

The leading thread runs speculatively. At every branch it records the current tail pointer in a checkpoint slot selected by a tag. When that branch turns out to be mispredicted, the tail is moved back to the recorded value. Every entry pushed on the wrong path is then dropped and is never shown to the trailing thread.

A three-state controller tracks occupancy. The states are `Q_EMPTY`, `Q_PARTIAL` and `Q_FULL`. The fill transition goes from `Q_EMPTY` to `Q_PARTIAL` and from `Q_PARTIAL` to `Q_FULL`. The drain transition goes from `Q_FULL` to `Q_PARTIAL` and from `Q_PARTIAL` to `Q_EMPTY`. The rollback transition leads from any state to the state that matches the restored occupancy. The next state is always picked from the occupancy the queue will hold after the current cycle. The default depth is 16 entries, and 64 is equally valid.

Top module: `speculative_load_value_queue`

## Requirements
- R1: After reset the queue is empty, `trail_ready` is 0 and `lead_ready` is 1.
- R2: Entries pushed while `lead_ready` is 1 are presented on `trail_data` in push order, one per accepted pop. A push and a pop in the same cycle are both accepted.
- R3: With DEPTH entries held, `lead_ready` is 0 and a push attempt is ignored: after draining, only the first DEPTH values appear and the queue then reports empty.
- R4: A pop request on an empty queue stalls (`trail_ready` is 0) and consumes nothing; the next pushed entry is the next one presented.
- R5: A checkpoint records the tail as it stands after any push accepted in the same cycle, so that push survives a later rollback to that checkpoint.
- R6: A restore sets the tail to the recorded value for the given tag. A push in the restore cycle is ignored. Squashed entries are never presented.
- R7: A pop accepted while a restore is applied is served from the current head.
- R8: `trail_addr_mismatch` is 1 in exactly the cycle of an accepted pop whose `trail_addr` differs from the stored address, and 0 otherwise.
- R9: The check bit is even parity: `lead_chk` must equal the XOR of all bits of `lead_addr` and `lead_data`. `trail_chk_error` is 1 in the cycle of an accepted pop whose stored bit breaks that rule, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_valid | input | 1 | Leading thread offers a load entry |
| lead_ready | output | 1 | Queue can accept an entry (not full) |
| lead_addr | input | ADDR_W | Leading load address |
| lead_data | input | DATA_W | Value read from the data cache |
| lead_chk | input | 1 | Even parity bit over address and value |
| br_ckpt_valid | input | 1 | Record the tail for a branch |
| br_ckpt_tag | input | TAG_W | Checkpoint slot for that branch |
| br_restore_valid | input | 1 | Misprediction: roll the tail back |
| br_restore_tag | input | TAG_W | Slot whose recorded tail is restored |
| trail_valid | input | 1 | Trailing thread requests a pop |
| trail_ready | output | 1 | Head entry present; a pop is accepted |
| trail_addr | input | ADDR_W | Address computed by the trailing load |
| trail_data | output | DATA_W | Value of the head entry |
| trail_addr_mismatch | output | 1 | Popped address differs from the stored one |
| trail_chk_error | output | 1 | Stored check bit failed on pop |

## Verification
The hardest case to reach is a rollback that drops entries and, in the same cycle, races a pop, a new push and the trailing thread's drive to reach the squashed data. The stimulus table builds this on purpose. It takes a checkpoint together with a push, pushes two wrong-path loads, and then restores while popping and pushing at once. The next pop on the now empty queue must stall rather than show the squashed values. A corrupted check bit is injected by driving a wrong `lead_chk` on one push.

// File: rtl/lvq_pkg.sv
package lvq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;

endpackage

// File: rtl/lvq_storage.sv
module lvq_storage #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_chk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_chk
);

    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic              chk_mem  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                addr_mem[g] <= wr_addr;
                data_mem[g] <= wr_data;
                chk_mem[g]  <= wr_chk;
            end
        end
    end

    assign rd_addr = addr_mem[rd_idx];
    assign rd_data = data_mem[rd_idx];
    assign rd_chk  = chk_mem[rd_idx];

endmodule

// File: rtl/lvq_ckpt_table.sv
module lvq_ckpt_table #(
    parameter int NUM_CKPT = 8,
    parameter int PTR_W    = 5,
    localparam int TAG_W   = $clog2(NUM_CKPT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [TAG_W-1:0] rd_tag,
    output logic [PTR_W-1:0] rd_ptr
);

    logic [PTR_W-1:0] snap_q [NUM_CKPT];

    for (genvar g = 0; g < NUM_CKPT; g++) begin : g_ckpt
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap_q[g] <= '0;
            end else if (wr_en && (wr_tag == TAG_W'(g))) begin
                snap_q[g] <= wr_ptr;
            end
        end
    end

    assign rd_ptr = snap_q[rd_tag];

endmodule

// File: rtl/lvq_ctrl.sv
module lvq_ctrl
    import lvq_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             restore_en,
    input  logic [PTR_W-1:0] restore_ptr,
    output logic             push_fire,
    output logic             pop_fire,
    output logic             can_push,
    output logic             can_pop,
    output logic [PTR_W-1:0] head_q,
    output logic [PTR_W-1:0] tail_q,
    output logic [PTR_W-1:0] tail_after_push
);

    localparam logic [PTR_W-1:0] ONE_P   = PTR_W'(1);
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

    q_state_e         state_q, state_nxt;
    logic [PTR_W-1:0] head_nxt, tail_nxt, cnt_nxt, cnt_q;

    // outputs decoded from the state register
    always_comb begin
        unique case (state_q)
            Q_EMPTY:   begin can_pop = 1'b0; can_push = 1'b1; end
            Q_PARTIAL: begin can_pop = 1'b1; can_push = 1'b1; end
            Q_FULL:    begin can_pop = 1'b1; can_push = 1'b0; end
            default:   begin can_pop = 1'b0; can_push = 1'b0; end
        endcase
    end

    assign push_fire       = push_req && can_push && !restore_en;
    assign pop_fire        = pop_req && can_pop;
    assign tail_after_push = push_fire ? tail_q + ONE_P : tail_q;
    assign head_nxt        = pop_fire ? head_q + ONE_P : head_q;
    assign tail_nxt        = restore_en ? restore_ptr : tail_after_push;
    assign cnt_nxt         = tail_nxt - head_nxt;
    assign cnt_q           = tail_q - head_q;

    // fill / drain / rollback transitions
    always_comb begin
        if (cnt_nxt == '0) begin
            state_nxt = Q_EMPTY;
        end else if (cnt_nxt == DEPTH_P) begin
            state_nxt = Q_FULL;
        end else begin
            state_nxt = Q_PARTIAL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_nxt;
            head_q  <= head_nxt;
            tail_q  <= tail_nxt;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEPTH_P);

    assert_state_matches_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == Q_EMPTY) == (cnt_q == '0));

    assert_push_advances_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push_fire |=> tail_q == $past(tail_q) + ONE_P);

    assert_empty_pop_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && state_q == Q_EMPTY) |=> head_q == $past(head_q));

    assert_restore_sets_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> tail_q == $past(restore_ptr));

endmodule

// File: rtl/speculative_load_value_queue.sv
module speculative_load_value_queue #(
    parameter int DEPTH    = 16,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_CKPT = 8,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int PTR_W   = IDX_W + 1,
    localparam int TAG_W   = $clog2(NUM_CKPT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_valid,
    output logic              lead_ready,
    input  logic [ADDR_W-1:0] lead_addr,
    input  logic [DATA_W-1:0] lead_data,
    input  logic              lead_chk,
    input  logic              br_ckpt_valid,
    input  logic [TAG_W-1:0]  br_ckpt_tag,
    input  logic              br_restore_valid,
    input  logic [TAG_W-1:0]  br_restore_tag,
    input  logic              trail_valid,
    output logic              trail_ready,
    input  logic [ADDR_W-1:0] trail_addr,
    output logic [DATA_W-1:0] trail_data,
    output logic              trail_addr_mismatch,
    output logic              trail_chk_error
);

    logic             push_fire, pop_fire, can_push, can_pop;
    logic [PTR_W-1:0] head_q, tail_q, tail_after_push, restore_ptr;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic              head_chk;

    lvq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .push_req        (lead_valid),
        .pop_req         (trail_valid),
        .restore_en      (br_restore_valid),
        .restore_ptr     (restore_ptr),
        .push_fire       (push_fire),
        .pop_fire        (pop_fire),
        .can_push        (can_push),
        .can_pop         (can_pop),
        .head_q          (head_q),
        .tail_q          (tail_q),
        .tail_after_push (tail_after_push)
    );

    lvq_ckpt_table #(.NUM_CKPT(NUM_CKPT), .PTR_W(PTR_W)) u_ckpt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (br_ckpt_valid && !br_restore_valid),
        .wr_tag (br_ckpt_tag),
        .wr_ptr (tail_after_push),
        .rd_tag (br_restore_tag),
        .rd_ptr (restore_ptr)
    );

    lvq_storage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (push_fire),
        .wr_idx  (tail_q[IDX_W-1:0]),
        .wr_addr (lead_addr),
        .wr_data (lead_data),
        .wr_chk  (lead_chk),
        .rd_idx  (head_q[IDX_W-1:0]),
        .rd_addr (head_addr),
        .rd_data (head_data),
        .rd_chk  (head_chk)
    );

    assign lead_ready          = can_push;
    assign trail_ready         = can_pop;
    assign trail_data          = head_data;
    assign trail_addr_mismatch = pop_fire && (trail_addr != head_addr);
    assign trail_chk_error     = pop_fire && (head_chk != ^{head_addr, head_data});

    assert_mismatch_needs_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trail_addr_mismatch |-> (trail_valid && trail_ready));

    assert_chk_error_needs_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trail_chk_error |-> (trail_valid && trail_ready));

    assert_no_push_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lead_ready |=> tail_q == $past(tail_q) || $past(br_restore_valid));

endmodule

// File: tb/speculative_load_value_queue_tb.sv
module speculative_load_value_queue_tb;

    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int NCK   = 4;
    localparam int TW    = 2;

    typedef struct packed {
        logic          push;
        logic [AW-1:0] paddr;
        logic [DW-1:0] pdata;
        logic          pbad;
        logic          pop;
        logic [AW-1:0] taddr;
        logic          ck;
        logic          rs;
        logic [TW-1:0] tag;
        logic          e_rdy;
        logic [DW-1:0] e_data;
        logic          e_mis;
        logic          e_perr;
        logic          e_lrdy;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        // R4: pop on empty stalls while first push lands
        '{1'b1, 16'h10, 16'h100, 1'b0, 1'b1, 16'h0,  1'b0, 1'b0, 2'd0, 1'b0, 16'h0,   1'b0, 1'b0, 1'b1},
        // R2/R5: push+pop together, checkpoint taken with a push
        '{1'b1, 16'h11, 16'h101, 1'b0, 1'b1, 16'h10, 1'b1, 1'b0, 2'd0, 1'b1, 16'h100, 1'b0, 1'b0, 1'b1},
        // wrong-path pushes
        '{1'b1, 16'h12, 16'h102, 1'b0, 1'b0, 16'h0,  1'b0, 1'b0, 2'd0, 1'b1, 16'h101, 1'b0, 1'b0, 1'b1},
        '{1'b1, 16'h13, 16'h103, 1'b0, 1'b0, 16'h0,  1'b0, 1'b0, 2'd0, 1'b1, 16'h101, 1'b0, 1'b0, 1'b1},
        // R6/R7: restore with push ignored and pop served
        '{1'b1, 16'h14, 16'h104, 1'b0, 1'b1, 16'h11, 1'b0, 1'b1, 2'd0, 1'b1, 16'h101, 1'b0, 1'b0, 1'b1},
        // R6: squashed entries not presented
        '{1'b1, 16'h15, 16'h105, 1'b0, 1'b1, 16'h0,  1'b0, 1'b0, 2'd0, 1'b0, 16'h0,   1'b0, 1'b0, 1'b1},
        // R8: wrong trailing address
        '{1'b0, 16'h0,  16'h0,   1'b0, 1'b1, 16'h99, 1'b0, 1'b0, 2'd0, 1'b1, 16'h105, 1'b1, 1'b0, 1'b1},
        // R9: bad check bit stored
        '{1'b1, 16'h16, 16'h106, 1'b1, 1'b0, 16'h0,  1'b0, 1'b0, 2'd0, 1'b0, 16'h0,   1'b0, 1'b0, 1'b1},
        '{1'b0, 16'h0,  16'h0,   1'b0, 1'b1, 16'h16, 1'b0, 1'b0, 2'd0, 1'b1, 16'h106, 1'b0, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lead_valid, lead_ready, lead_chk;
    logic [AW-1:0] lead_addr, trail_addr;
    logic [DW-1:0] lead_data, trail_data;
    logic          br_ckpt_valid, br_restore_valid;
    logic [TW-1:0] br_ckpt_tag, br_restore_tag;
    logic          trail_valid, trail_ready, trail_addr_mismatch, trail_chk_error;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    speculative_load_value_queue #(
        .DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .NUM_CKPT(NCK)
    ) u_dut (
        .clk                 (clk),
        .rst_n               (rst_n),
        .lead_valid          (lead_valid),
        .lead_ready          (lead_ready),
        .lead_addr           (lead_addr),
        .lead_data           (lead_data),
        .lead_chk            (lead_chk),
        .br_ckpt_valid       (br_ckpt_valid),
        .br_ckpt_tag         (br_ckpt_tag),
        .br_restore_valid    (br_restore_valid),
        .br_restore_tag      (br_restore_tag),
        .trail_valid         (trail_valid),
        .trail_ready         (trail_ready),
        .trail_addr          (trail_addr),
        .trail_data          (trail_data),
        .trail_addr_mismatch (trail_addr_mismatch),
        .trail_chk_error     (trail_chk_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        lead_valid = 1'b0; lead_addr = '0; lead_data = '0; lead_chk = 1'b0;
        br_ckpt_valid = 1'b0; br_ckpt_tag = '0;
        br_restore_valid = 1'b0; br_restore_tag = '0;
        trail_valid = 1'b0; trail_addr = '0;
    endtask

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic bad);
        lead_valid = 1'b1; lead_addr = a; lead_data = d;
        lead_chk = (^{a, d}) ^ bad;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1 trail_ready", 32'(trail_ready), 32'd0);
        check("R1 lead_ready", 32'(lead_ready), 32'd1);
        check("R8 idle mismatch", 32'(trail_addr_mismatch), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            if (TBL[i].push) push(TBL[i].paddr, TBL[i].pdata, TBL[i].pbad);
            trail_valid      = TBL[i].pop;
            trail_addr       = TBL[i].taddr;
            br_ckpt_valid    = TBL[i].ck;
            br_ckpt_tag      = TBL[i].tag;
            br_restore_valid = TBL[i].rs;
            br_restore_tag   = TBL[i].tag;
            #2;
            check($sformatf("R2 row%0d trail_ready", i), 32'(trail_ready), 32'(TBL[i].e_rdy));
            check($sformatf("R3 row%0d lead_ready", i), 32'(lead_ready), 32'(TBL[i].e_lrdy));
            if (TBL[i].e_rdy)
                check($sformatf("R2 row%0d trail_data", i), 32'(trail_data), 32'(TBL[i].e_data));
            check($sformatf("R8 row%0d mismatch", i), 32'(trail_addr_mismatch), 32'(TBL[i].e_mis));
            check($sformatf("R9 row%0d chk_error", i), 32'(trail_chk_error), 32'(TBL[i].e_perr));
        end

        // R3: fill to DEPTH, extra push ignored, drain in order
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            idle();
            push(AW'(16'h20 + i), DW'(16'h200 + i), 1'b0);
        end
        @(negedge clk);
        idle();
        push(16'h2F, 16'h2FF, 1'b0);
        #2;
        check("R3 lead_ready when full", 32'(lead_ready), 32'd0);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            idle();
            trail_valid = 1'b1;
            trail_addr  = AW'(16'h20 + i);
            #2;
            check("R3 drain ready", 32'(trail_ready), 32'd1);
            check("R2 drain order", 32'(trail_data), 32'(16'h200 + i));
            check("R8 drain match", 32'(trail_addr_mismatch), 32'd0);
        end
        @(negedge clk);
        idle();
        trail_valid = 1'b1;
        #2;
        check("R3 overflow push dropped", 32'(trail_ready), 32'd0);
        check("R3 lead_ready after drain", 32'(lead_ready), 32'd1);

        @(negedge clk);
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule